// File: doc/BRIEF.md
# FIFO Threshold Flag Unit

This block sits beside the storage and pointer logic of a dual-clock FIFO. From occupancy counts that the enclosing FIFO supplies, it raises two early-warning flags. One says the queue is nearly drained and is registered on the read clock. The other says the queue is nearly full and is registered on the write clock. Each flag compares a level against its own programmable margin register.

Both margins take one of two preset values at master reset. A select input, sampled while master reset is held, chooses which preset applies. After reset, software-side logic can rewrite the margins in one of two ways. The first is a bit-serial stream on the write clock. The second is a pair of parallel load cycles from the data bus; these cycles carry configuration only, never FIFO data. A partial reset clears the flags and restarts the parallel load sequence but keeps the margins that were programmed. Only a master reset brings back the presets.

Top module: `fifo_thresh_flags`

## Requirements
- R1: On a write-clock edge with `mrst_n` low, both margins load the preset: 7 when `dflt_sel` is 0, 31 when it is 1 (defaults of `DFLT_LO` and `DFLT_HI`). The parallel load sequence also returns to its first step.
- R2: `almost_empty` becomes 1 on the rising `rclk` edge after `rd_count` is at or below the empty-side margin, and 0 otherwise.
- R3: `almost_full` becomes 1 on the rising `wclk` edge after the free space, `DEPTH - wr_count`, is at or below the full-side margin, and 0 otherwise.
- R4: Each `wclk` edge with `ser_en` high and `ld_en` low shifts in `ser_in`. The first `OFF_W` bits go to the empty-side margin, least significant bit first. The next `OFF_W` bits go to the full-side margin, in the same bit order.
- R5: Each `wclk` edge with `ld_en` high writes `din[OFF_W-1:0]` to one margin. The steps alternate: the empty-side margin first, then the full-side margin, then the empty side again. Bits of `din` above `OFF_W-1` have no effect.
- R6: A `wclk` edge with `prst_n` low and `mrst_n` high leaves both margins unchanged. It returns the parallel load sequence to the empty-side step.
- R7: While either `mrst_n` or `prst_n` is low, each flag is driven to 0 at its own clock edge, whatever the counts are.
- R8: When `ld_en` and `ser_en` are both high, the parallel load takes effect and the serial bit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| dflt_sel | input | 1 | Chooses the preset margin at master reset |
| ld_en | input | 1 | Parallel margin load strobe |
| ser_en | input | 1 | Serial margin shift strobe |
| ser_in | input | 1 | Serial margin data bit |
| din | input | DATA_W | Data bus; the low OFF_W bits carry a margin |
| wr_count | input | CNT_W | Occupancy seen in the write domain |
| rd_count | input | CNT_W | Occupancy seen in the read domain |
| almost_empty | output | 1 | Near-empty flag, registered on rclk |
| almost_full | output | 1 | Near-full flag, registered on wclk |

## Verification
The bench drives counts exactly at each margin and one step past it. An off-by-one comparison, or a full flag computed from occupancy instead of free space, would then flip a flag on the wrong vector. A parallel load followed by a partial reset and another load checks that the sequence restarts on the empty side. A design that kept the step pointer would instead overwrite the full-side margin. A serial stream with different values for the two margins catches a wrong bit order or swapped margins. A partial reset must keep the programmed margins, while a master reset with each select value must restore the right preset. Finally, strobing load and shift together shows whether the serial path wrongly corrupts the margins.

// File: rtl/thf_pkg.sv
package thf_pkg;

  typedef enum logic {
    SLOT_EMPTY_SIDE = 1'b0,
    SLOT_FULL_SIDE  = 1'b1
  } load_slot_e;

  // space left in a queue of the given depth
  function automatic int unsigned free_slots(int unsigned depth, int unsigned used);
    return (used >= depth) ? 0 : depth - used;
  endfunction

  // a level counts as "near" when it does not exceed the margin
  function automatic logic within_margin(int unsigned level, int unsigned margin);
    return level <= margin;
  endfunction

  function automatic int unsigned preset_pick(logic sel, int unsigned lo, int unsigned hi);
    return sel ? hi : lo;
  endfunction

endpackage

// File: rtl/thf_offset_bank.sv
module thf_offset_bank
  import thf_pkg::*;
#(
  parameter int OFF_W   = 6,
  parameter int DATA_W  = 18,
  parameter int DFLT_LO = 7,
  parameter int DFLT_HI = 31
) (
  input  logic              wclk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              dflt_sel,
  input  logic              ld_en,
  input  logic              ser_en,
  input  logic              ser_in,
  input  logic [DATA_W-1:0] din,
  output logic [OFF_W-1:0]  ae_off,
  output logic [OFF_W-1:0]  af_off
);

  localparam int unsigned LO_U = DFLT_LO;
  localparam int unsigned HI_U = DFLT_HI;

  load_slot_e       slot;
  logic [OFF_W-1:0] preset_val;
  logic [OFF_W-1:0] bus_val;
  logic             run;
  logic             wr_ae;
  logic             wr_af;
  logic             shift_go;

  assign preset_val = OFF_W'(preset_pick(dflt_sel, LO_U, HI_U));
  assign bus_val    = din[OFF_W-1:0];
  assign run        = mrst_n && prst_n;
  assign wr_ae      = run && ld_en && (slot == SLOT_EMPTY_SIDE);
  assign wr_af      = run && ld_en && (slot == SLOT_FULL_SIDE);
  assign shift_go   = run && ser_en && !ld_en;

  generate
    if (DATA_W > OFF_W) begin : g_high
      logic din_high_unused;
      assign din_high_unused = ^din[DATA_W-1:OFF_W];
    end
  endgenerate

  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      ae_off <= preset_val;
      af_off <= preset_val;
      slot   <= SLOT_EMPTY_SIDE;
    end else if (!prst_n) begin
      slot <= SLOT_EMPTY_SIDE;
    end else begin
      if (wr_ae) ae_off <= bus_val;
      if (wr_af) af_off <= bus_val;
      if (shift_go) {af_off, ae_off} <= {ser_in, af_off, ae_off[OFF_W-1:1]};
      if (ld_en) slot <= (slot == SLOT_EMPTY_SIDE) ? SLOT_FULL_SIDE : SLOT_EMPTY_SIDE;
    end
  end

  logic past_ok = 1'b0;
  always_ff @(posedge wclk) past_ok <= 1'b1;

  // R1
  preset_load_chk: assert property (@(posedge wclk)
    past_ok && $past(!mrst_n) |-> (ae_off == $past(preset_val)) && (af_off == $past(preset_val)));

  // R6
  partial_keep_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
    past_ok && $past(mrst_n && !prst_n) |-> $stable(ae_off) && $stable(af_off));

  // R4
  serial_shift_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
    past_ok && $past(shift_go) |-> ae_off == {$past(af_off[0]), $past(ae_off[OFF_W-1:1])});

  // R5
  parallel_empty_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
    past_ok && $past(wr_ae) |-> (ae_off == $past(bus_val)) && $stable(af_off));

endmodule

// File: rtl/thf_level_flag.sv
module thf_level_flag
  import thf_pkg::*;
#(
  parameter int CNT_W      = 7,
  parameter int OFF_W      = 6,
  parameter int DEPTH      = 64,
  parameter bit COUNT_FREE = 1'b0
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [OFF_W-1:0] margin,
  output logic             flag
);

  localparam int unsigned DEPTH_U = DEPTH;

  int unsigned level;
  logic        near;
  logic        run;

  generate
    if (COUNT_FREE) begin : g_free
      assign level = free_slots(DEPTH_U, 32'(count));
    end else begin : g_used
      assign level = 32'(count);
    end
  endgenerate

  assign near = within_margin(level, 32'(margin));
  assign run  = mrst_n && prst_n;

  always_ff @(posedge clk) begin
    if (!run) flag <= 1'b0;
    else      flag <= near;
  end

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  // R7
  flag_idle_chk: assert property (@(posedge clk)
    past_ok && $past(!run) |-> !flag);

  // R2, R3
  flag_track_chk: assert property (@(posedge clk) disable iff (!run)
    past_ok && $past(run) |-> flag == $past(near));

endmodule

// File: rtl/fifo_thresh_flags.sv
module fifo_thresh_flags #(
  parameter int DEPTH   = 64,
  parameter int DATA_W  = 18,
  parameter int DFLT_LO = 7,
  parameter int DFLT_HI = 31,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int OFF_W  = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              dflt_sel,
  input  logic              ld_en,
  input  logic              ser_en,
  input  logic              ser_in,
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  wr_count,
  input  logic [CNT_W-1:0]  rd_count,
  output logic              almost_empty,
  output logic              almost_full
);

  logic [OFF_W-1:0] ae_off;
  logic [OFF_W-1:0] af_off;

  thf_offset_bank #(
    .OFF_W(OFF_W), .DATA_W(DATA_W), .DFLT_LO(DFLT_LO), .DFLT_HI(DFLT_HI)
  ) u_bank (
    .wclk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .dflt_sel(dflt_sel),
    .ld_en(ld_en), .ser_en(ser_en), .ser_in(ser_in), .din(din),
    .ae_off(ae_off), .af_off(af_off)
  );

  thf_level_flag #(
    .CNT_W(CNT_W), .OFF_W(OFF_W), .DEPTH(DEPTH), .COUNT_FREE(1'b0)
  ) u_empty_side (
    .clk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .count(rd_count), .margin(ae_off), .flag(almost_empty)
  );

  thf_level_flag #(
    .CNT_W(CNT_W), .OFF_W(OFF_W), .DEPTH(DEPTH), .COUNT_FREE(1'b1)
  ) u_full_side (
    .clk(wclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .count(wr_count), .margin(af_off), .flag(almost_full)
  );

endmodule

// File: tb/fifo_thresh_flags_bench.sv
module fifo_thresh_flags_bench;

  localparam int DEPTH = 64;
  localparam int DATA_W = 18;

  logic clk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, dflt_sel = 1'b0;
  logic ld_en = 1'b0, ser_en = 1'b0, ser_in = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [6:0] wr_count = '0, rd_count = '0;
  logic almost_empty, almost_full;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fifo_thresh_flags u_fifo_thresh_flags (
    .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .dflt_sel(dflt_sel),
    .ld_en(ld_en), .ser_en(ser_en), .ser_in(ser_in), .din(din),
    .wr_count(wr_count), .rd_count(rd_count),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  // {rd_count, wr_count, expected almost_empty, expected almost_full}, margins 7/7
  localparam logic [15:0] VEC [10] = '{
    {7'd0,  7'd64, 1'b1, 1'b1},
    {7'd7,  7'd57, 1'b1, 1'b1},
    {7'd8,  7'd56, 1'b0, 1'b0},
    {7'd63, 7'd0,  1'b0, 1'b0},
    {7'd6,  7'd58, 1'b1, 1'b1},
    {7'd8,  7'd57, 1'b0, 1'b1},
    {7'd7,  7'd56, 1'b1, 1'b0},
    {7'd32, 7'd32, 1'b0, 1'b0},
    {7'd64, 7'd1,  1'b0, 1'b0},
    {7'd1,  7'd63, 1'b1, 1'b1}
  };

  task automatic expect1(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  // apply counts, let one edge register the flags, compare
  task automatic probe(input int rd, input int wr, input logic e_ae, input logic e_af,
                       input string tag);
    rd_count = 7'(rd);
    wr_count = 7'(wr);
    @(negedge clk);
    expect1(almost_empty, e_ae, {tag, " almost_empty"});
    expect1(almost_full,  e_af, {tag, " almost_full"});
  endtask

  task automatic master_reset(input logic sel);
    rd_count = 7'd0;
    wr_count = 7'd64;
    mrst_n = 1'b0;
    dflt_sel = sel;
    @(negedge clk);
    expect1(almost_empty, 1'b0, "R7 master reset almost_empty");
    expect1(almost_full,  1'b0, "R7 master reset almost_full");
    mrst_n = 1'b1;
  endtask

  task automatic pload(input logic [DATA_W-1:0] v);
    ld_en = 1'b1;
    din = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic sshift(input int v, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      ser_en = 1'b1;
      ser_in = v[i];
      @(negedge clk);
    end
    ser_en = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    master_reset(1'b0);
    // R1 preset 7 and R2/R3 compare at and around the margin
    for (int k = 0; k < 10; k++) begin
      probe(int'(VEC[k][15:9]), int'(VEC[k][8:2]), VEC[k][1], VEC[k][0],
            $sformatf("R1 R2 R3 vector %0d", k));
    end

    // R1 other preset
    master_reset(1'b1);
    probe(31, 33, 1'b1, 1'b1, "R1 preset 31 edge");
    probe(32, 32, 1'b0, 1'b0, "R1 preset 31 past");

    // R5 parallel: empty side 10 (upper bits set), then full side 20
    pload(18'h3FFC0 | 18'd10);
    pload(18'h2AA80 | 18'd20);
    probe(10, 44, 1'b1, 1'b1, "R5 parallel edge");
    probe(11, 43, 1'b0, 1'b0, "R5 parallel past");

    // R6 one load step, partial reset, margins kept, sequence restarts
    pload(18'd5);
    rd_count = 7'd0;
    wr_count = 7'd64;
    prst_n = 1'b0;
    @(negedge clk);
    expect1(almost_empty, 1'b0, "R7 partial reset almost_empty");
    expect1(almost_full,  1'b0, "R7 partial reset almost_full");
    prst_n = 1'b1;
    probe(5, 44, 1'b1, 1'b1, "R6 kept edge");
    probe(6, 43, 1'b0, 1'b0, "R6 kept past");
    pload(18'd12);
    probe(12, 44, 1'b1, 1'b1, "R6 restart edge");
    probe(13, 43, 1'b0, 1'b0, "R6 restart past");

    // R4 serial: empty side 9, full side 40, LSB first
    master_reset(1'b0);
    sshift(9, 6);
    sshift(40, 6);
    probe(9, 24, 1'b1, 1'b1, "R4 serial edge");
    probe(10, 23, 1'b0, 1'b0, "R4 serial past");

    // R8 load and shift together: parallel wins, serial ignored
    master_reset(1'b0);
    ld_en = 1'b1;
    ser_en = 1'b1;
    ser_in = 1'b1;
    din = 18'd2;
    @(negedge clk);
    ld_en = 1'b0;
    ser_en = 1'b0;
    probe(2, 57, 1'b1, 1'b1, "R8 priority edge");
    probe(3, 56, 1'b0, 1'b0, "R8 priority past");

    // R1 master reset restores preset after programming
    master_reset(1'b0);
    probe(7, 57, 1'b1, 1'b1, "R1 restore edge");
    probe(8, 56, 1'b0, 1'b0, "R1 restore past");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule